// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port with Open-Drain Option

This block is a general-purpose I/O port with eight pins. Software reaches it over a small register bus with one write strobe. The bus exposes three registers: a port data register, a direction register and a control register. The control register holds a single bit that turns every pin into an open-drain output at once. Each pin leaves the block as an output value plus its own output enable. A pad wrapper above the block joins each pair into a tri-state pad. Each pin comes back in through `pin_in`, and a two-stage synchronizer sits on that path before the pin can be read.

The direction bit of each pin has two jobs. It enables that pin's driver. It also picks what a data read returns for that bit: the output latch when the pin is an output, or the synchronized pin level when it is an input. With open-drain selected, a latch bit of 0 pulls its pin low, and a latch bit of 1 releases the pin so an external pull-up can raise it. The open-drain bit takes effect only while `single_chip` is high. In any other operating mode the port drives push-pull whatever the bit holds.

Top module: `gpio_od_port`

## Requirements
- R1: Reset (synchronous, active high) clears the direction register, the output latch and the open-drain bit. Directly after reset, `pin_oe` is 0, `pin_out` is 0, and reads of the direction and control registers return 0.
- R2: A write with `reg_addr`=1 loads the direction register. From the next clock edge on, a read at `reg_addr`=1 returns the written value on `reg_rdata`.
- R3: With push-pull drive in effect, each `pin_oe` bit equals its direction bit. A pin whose direction bit is 0 is never driven.
- R4: A read at `reg_addr`=0 returns the output latch in every bit whose direction bit is 1.
- R5: A read at `reg_addr`=0 returns the pin level in every bit whose direction bit is 0, taken through two register stages. A change on `pin_in` that lands just after edge k is still hidden after edge k+1 and becomes readable after edge k+2.
- R6: A write with `reg_addr`=0 always loads the output latch, including bits whose pins are inputs. The value becomes visible once those pins are switched to outputs.
- R7: The open-drain bit is control bit 0, at `reg_addr`=2. When it is 1 and `single_chip` is 1, every output pin whose latch bit is 0 has `pin_oe`=1 and `pin_out`=0, and every pin whose latch bit is 1 has `pin_oe`=0.
- R8: When `single_chip` is 0, the open-drain bit has no effect on `pin_oe`, and the bit keeps its stored value.
- R9: A read at `reg_addr`=2 returns the open-drain bit in bit 0 and 0 in bits 7..1. Write data bits 7..1 at that address are ignored. A read at `reg_addr`=3 returns 0.
- R10: `pin_out` always presents the output latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_chip | input | 1 | High when the device runs in single-chip mode; allows open-drain |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 control, 3 reserved |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the register selected by `reg_addr` (combinational) |
| pin_in | input | 8 | Level sensed at each pad |
| pin_out | output | 8 | Value offered to each pad driver |
| pin_oe | output | 8 | Output enable for each pad driver |

## Verification
A register write becomes visible one edge after the strobe, so it appears on the `reg_rdata` read-back and on the `pin_oe`/`pin_out` drive in the following cycle. A change of `single_chip` shows on the drive in the same cycle. A pin change reaches a data read only after two edges. The driver task pushes each expected item only after it has placed the stimulus and waited the matching number of edges. The monitor compares items at the falling edge, halfway between updates. The synchronizer check pushes an item for the old value after one edge and for the new value after two, so a stage too many or too few is caught.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

    localparam int ADDR_W      = 2;
    localparam int CTRL_OD_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_CTRL = 2'd2,
        REG_RSVD = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      wr;
        reg_addr_e addr;
    } bus_cmd_t;

    // Open-drain only counts while the device is in single-chip mode.
    function automatic logic od_effective(input logic od_bit, input logic single_chip);
        return od_bit & single_chip;
    endfunction

endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_od_regs.sv
module gpio_od_regs
    import gpio_od_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_cmd_t     cmd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] ddr_q,
    output logic [W-1:0] latch_q,
    output logic         od_q,
    output logic [W-1:0] rdata
);
    logic [W-1:0] data_view;
    logic [W-1:0] ctrl_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            ddr_q   <= '0;
            latch_q <= '0;
            od_q    <= 1'b0;
        end else if (cmd.wr) begin
            unique case (cmd.addr)
                REG_DATA: latch_q <= wdata;
                REG_DIR:  ddr_q   <= wdata;
                REG_CTRL: od_q    <= wdata[CTRL_OD_BIT];
                default:  ;
            endcase
        end
    end

    // Per-bit source selection for data reads.
    generate
        for (genvar i = 0; i < W; i++) begin : g_view
            assign data_view[i] = ddr_q[i] ? latch_q[i] : pin_sync[i];
        end
    endgenerate

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[CTRL_OD_BIT] = od_q;
    end

    always_comb begin
        unique case (cmd.addr)
            REG_DATA: rdata = data_view;
            REG_DIR:  rdata = ddr_q;
            REG_CTRL: rdata = ctrl_view;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_od_drive.sv
module gpio_od_drive
    import gpio_od_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] ddr_q,
    input  logic [W-1:0] latch_q,
    input  logic         od_q,
    input  logic         single_chip,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    logic od_on;
    assign od_on = od_effective(od_q, single_chip);

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            // Open-drain: the high side is off, so a 1 releases the pin.
            assign pin_oe[i]  = ddr_q[i] & ~(od_on & latch_q[i]);
            assign pin_out[i] = latch_q[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
    import gpio_od_pkg::*;
#(
    parameter int W         = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single_chip,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    bus_cmd_t     cmd;
    logic [W-1:0] pin_sync;
    logic [W-1:0] ddr_q;
    logic [W-1:0] latch_q;
    logic         od_q;

    assign cmd.wr   = reg_wr;
    assign cmd.addr = reg_addr_e'(reg_addr);

    gpio_od_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_od_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .ddr_q    (ddr_q),
        .latch_q  (latch_q),
        .od_q     (od_q),
        .rdata    (reg_rdata)
    );

    gpio_od_drive #(.W(W)) u_drive (
        .ddr_q       (ddr_q),
        .latch_q     (latch_q),
        .od_q        (od_q),
        .single_chip (single_chip),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );
endmodule

// File: rtl/gpio_od_port_chk.sv
module gpio_od_port_chk
    import gpio_od_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              single_chip,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      reg_rdata,
    input logic [W-1:0]      pin_in,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      ddr_q,
    input logic [W-1:0]      latch_q,
    input logic              od_q
);
    logic [1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst)                     settle_cnt <= '0;
        else if (settle_cnt != 2'd3) settle_cnt <= settle_cnt + 2'd1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == REG_DIR) |=> (ddr_q == $past(reg_wdata)));

    p_oe_gated_r3: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & ~ddr_q) == '0));

    p_sync_read_r5: assert property (@(posedge clk) disable iff (rst)
        (settle_cnt >= 2'd2 && reg_addr == REG_DATA)
        |-> (((reg_rdata ^ $past(pin_in, 2)) & ~ddr_q) == '0));

    p_latch_write_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == REG_DATA) |=> (latch_q == $past(reg_wdata)));

    p_od_release_r7: assert property (@(posedge clk) disable iff (rst)
        (od_q && single_chip) |-> ((pin_oe & pin_out) == '0));

    p_push_pull_r8: assert property (@(posedge clk) disable iff (rst)
        !(od_q && single_chip) |-> (pin_oe == ddr_q));

    p_ctrl_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_CTRL) |-> (reg_rdata[W-1:1] == '0));
endmodule

bind gpio_od_port gpio_od_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .single_chip (single_chip),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .ddr_q       (ddr_q),
    .latch_q     (latch_q),
    .od_q        (od_q)
);

// File: tb/tb_gpio_od_port.sv
`timescale 1ns/1ps
module tb_gpio_od_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         single_chip;
    logic         reg_wr;
    logic [1:0]   reg_addr;
    logic [W-1:0] reg_wdata;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        int           kind;   // 0 rdata, 1 pin_out, 2 pin_oe
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    gpio_od_port #(.W(W)) dut (
        .clk         (clk),
        .rst         (rst),
        .single_chip (single_chip),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    // Monitor: compares queued expectations halfway through the cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            sb_item_t     it;
            logic [W-1:0] act;
            it  = sb.pop_front();
            act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? pin_out : pin_oe;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [W-1:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic chk_read(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        push(0, exp, tag);
        @(negedge clk); #1;
    endtask

    task automatic chk_pins(input logic [W-1:0] out_e, input logic [W-1:0] oe_e, input string tag);
        @(posedge clk); #1;
        push(1, out_e, tag);
        push(2, oe_e, tag);
        @(negedge clk); #1;
    endtask

    task automatic settle_pins(input logic [W-1:0] v);
        @(posedge clk); #1;
        pin_in = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        rst = 1'b1; single_chip = 1'b1; reg_wr = 1'b0;
        reg_addr = 2'd0; reg_wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk_read(2'd1, 8'h00, "R1 direction after reset");
        chk_read(2'd2, 8'h00, "R1 control after reset");
        chk_pins(8'h00, 8'h00, "R1 pins after reset");

        // R2, R3: direction write and push-pull enable
        bus_write(2'd1, 8'h5A);
        chk_read(2'd1, 8'h5A, "R2 direction readback");
        chk_pins(8'h00, 8'h5A, "R3 oe follows direction");

        // R4, R10: output read and pin_out
        bus_write(2'd0, 8'h33);
        bus_write(2'd1, 8'hFF);
        chk_read(2'd0, 8'h33, "R4 latch read all outputs");
        chk_pins(8'h33, 8'hFF, "R10 pin_out shows latch");

        // R5: two-stage synchronizer timing
        bus_write(2'd1, 8'h00);
        settle_pins(8'h00);
        @(posedge clk); #1;
        reg_addr = 2'd0;
        pin_in   = 8'hC3;
        push(0, 8'h00, "R5 before first edge");
        @(negedge clk); #1;
        chk_read(2'd0, 8'h00, "R5 hidden after one edge");
        chk_read(2'd0, 8'hC3, "R5 visible after two edges");

        // R4 + R5: mixed directions
        bus_write(2'd1, 8'hF0);
        bus_write(2'd0, 8'hA5);
        settle_pins(8'h3C);
        chk_read(2'd0, 8'hAC, "R4 R5 mixed source read");

        // R6: latch loads while pins are inputs
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h99);
        chk_pins(8'h99, 8'h00, "R6 no drive on inputs");
        bus_write(2'd1, 8'hFF);
        chk_read(2'd0, 8'h99, "R6 latch visible as output");

        // R7: open-drain in single-chip mode
        bus_write(2'd0, 8'h5A);
        bus_write(2'd2, 8'h01);
        chk_pins(8'h5A, 8'hA5, "R7 open-drain all outputs");
        bus_write(2'd1, 8'h0F);
        chk_pins(8'h5A, 8'h05, "R7 open-drain partial outputs");

        // R8: other modes ignore the open-drain bit
        @(posedge clk); #1 single_chip = 1'b0;
        chk_pins(8'h5A, 8'h0F, "R8 push-pull outside single-chip");
        bus_write(2'd1, 8'hFF);
        chk_pins(8'h5A, 8'hFF, "R8 full drive outside single-chip");
        chk_read(2'd2, 8'h01, "R8 open-drain bit kept");
        @(posedge clk); #1 single_chip = 1'b1;
        chk_pins(8'h5A, 8'hA5, "R7 open-drain back in single-chip");

        // R9: control register layout and reserved address
        bus_write(2'd2, 8'hFE);
        chk_read(2'd2, 8'h00, "R9 upper bits ignored");
        chk_pins(8'h5A, 8'hFF, "R9 open-drain cleared");
        bus_write(2'd2, 8'hFF);
        chk_read(2'd2, 8'h01, "R9 only bit 0 stored");
        chk_read(2'd3, 8'h00, "R9 reserved reads zero");

        // R1: reset in mid-run
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        chk_read(2'd1, 8'h00, "R1 direction after second reset");
        chk_read(2'd2, 8'h00, "R1 control after second reset");
        chk_pins(8'h00, 8'h00, "R1 pins after second reset");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
    end
endmodule